// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 512 word-wide control registers behind a simple 32-bit slave bus with zero wait states. It spans a 4 KiB byte window. Software writes a full word to a register and later reads the same word back. Four words come out of reset with fixed nonzero contents. Three status words always return bits 29 and 28 set on a read, whatever value was stored in them.

A write to one command offset also sends a single-cycle request to the chip's reset or power controller. The data value selects the request: 1 or 2 asks for a system reset, and 3 asks for a shutdown. Any other value raises no request.

Word indices from 512 upward fall in the upper half of the window and are not backed by storage. An access there stores nothing, reads zero and flags an error. The command offset lies in that upper half. Its requests still fire, but the written value is not kept.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds zero.
- R2: A full-word write at a byte offset below 0x800 stores `pwdata` at word index `paddr[11:2]`. A later read of that offset returns the stored word in its access phase.
- R3: A read at byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. A read at any other offset returns the stored word unchanged.
- R4: A write to byte offset 0xF00 with data 1 or 2 raises `resetReq` for exactly the one cycle that follows the access phase.
- R5: A write to byte offset 0xF00 with data 3 raises `shutdownReq` for exactly the one cycle that follows the access phase.
- R6: A write to offset 0xF00 with any other data value raises no request. A write of 1, 2 or 3 to any other offset also raises no request.
- R7: An access at byte offset 0x800 or above has the following effects. It drives `pslverr` high in its access phase. On a read it returns zero. On a write it changes no stored word, and in particular does not alias onto the lower words.
- R8: `pready` is always high. `prdata` is zero whenever no read access phase is in progress.
- R9: A setup phase (`psel` high, `penable` low) by itself neither stores data nor raises a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the read access phase |
| pready | output | 1 | Always high, zero wait states |
| pslverr | output | 1 | Out-of-range access flag |
| resetReq | output | 1 | One-cycle system reset request |
| shutdownReq | output | 1 | One-cycle system shutdown request |

## Verification
Reads taken right after reset tell the four preset words apart from the cleared ones. Reads of the three status words tell the forced bits apart from the stored value. The neighbouring word 0x104 and data patterns whose bits 29:28 are already zero or already set show whether forcing is confined to those three offsets. The command offset receives every request value, a zero and values just outside the request set, and request values are also written to an ordinary offset, so the two pulse outputs can each be separated from the other and from a plain store. Upper-window writes are followed by reads of word 0 to expose index aliasing, and setup-only phases show that nothing acts before `penable`.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W_DEF    = 12;
  localparam int DATA_W_DEF    = 32;
  localparam int IDX_W_DEF     = ADDR_W_DEF - 2;
  localparam int NUM_WORDS_DEF = 512;

  // strobes from the decoder to the register file
  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 outOfRange;
    logic [IDX_W_DEF-1:0] idx;
    logic                 reqReset;
    logic                 reqShutdown;
    logic                 forceBits;
  } ctrlStrobes_t;

  function automatic logic [DATA_W_DEF-1:0] resetWord(int i);
    case (i)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic logic isForcedIdx(logic [IDX_W_DEF-1:0] idx);
    return (idx == 10'h040) || (idx == 10'h042) || (idx == 10'h043);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  parameter int NUM_WORDS  = NUM_WORDS_DEF,
  parameter int CMD_OFFSET = 'hF00
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output ctrlStrobes_t      strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic             access;
  logic             inRange;
  logic             isCmd;
  logic [IDX_W-1:0] idx;

  always_comb begin
    access  = psel && penable;
    idx     = paddr[ADDR_W-1:2];
    inRange = 32'(idx) < NUM_WORDS;
    isCmd   = access && pwrite && (32'(paddr) == CMD_OFFSET);

    strb.wrEn        = access && pwrite && inRange;
    strb.rdEn        = access && !pwrite && inRange;
    strb.outOfRange  = access && !inRange;
    strb.idx         = idx;
    strb.reqReset    = isCmd && ((pwdata == DATA_W'(1)) || (pwdata == DATA_W'(2)));
    strb.reqShutdown = isCmd && (pwdata == DATA_W'(3));
    strb.forceBits   = isForcedIdx(idx);
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int DATA_W    = DATA_W_DEF,
  parameter int NUM_WORDS = NUM_WORDS_DEF,
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              resetReq,
  output logic              shutdownReq
);
  localparam int MEM_IDX_W = $clog2(NUM_WORDS);

  logic [DATA_W-1:0]    words [NUM_WORDS];
  logic [MEM_IDX_W-1:0] memIdx;

  assign memIdx = strb.idx[MEM_IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= resetWord(i);
    end else if (strb.wrEn) begin
      words[memIdx] <= pwdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      resetReq    <= strb.reqReset;
      shutdownReq <= strb.reqShutdown;
    end
  end

  always_comb begin
    prdata = '0;
    if (strb.rdEn) begin
      prdata = words[memIdx] | (strb.forceBits ? FORCE_MASK : '0);
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int DATA_W    = DATA_W_DEF,
  parameter int NUM_WORDS = NUM_WORDS_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              resetReq,
  output logic              shutdownReq
);
  ctrlStrobes_t strb;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
  ) decode_i (
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .strb(strb)
  );

  sysctl_regfile #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
  ) regfile_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pwdata(pwdata),
    .prdata(prdata), .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  assign pready  = 1'b1;
  assign pslverr = strb.outOfRange;
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic        resetReq,
  input logic        shutdownReq
);
  AST_PREADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    pready); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(psel && penable && !pwrite) |-> prdata == '0); // R8

  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R4

  AST_SHUTDOWN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !shutdownReq); // R5

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(psel && penable && pwrite && paddr == 12'hF00
                              && (pwdata == 32'd1 || pwdata == 32'd2))); // R4

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdownReq) |-> $past(psel && penable && pwrite && paddr == 12'hF00
                                 && pwdata == 32'd3)); // R5

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && shutdownReq)); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && paddr[11]) |-> (prdata == '0 && pslverr)); // R7

  AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite &&
     (paddr == 12'h100 || paddr == 12'h108 || paddr == 12'h10C))
    |-> prdata[29:28] == 2'b11); // R3
endmodule

bind sysctl_regs sysctl_checker chk_i (.*);

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, resetReq, shutdownReq;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [31:0] data;
    bit          err;
    string       req;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t cur;

  always #4 clk = ~clk; // 125 MHz

  sysctl_regs dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results in each read access phase
  always @(negedge clk) begin
    if (rstN && psel && penable && !pwrite) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", prdata, '0);
      end else begin
        cur = expQ.pop_front();
        check(prdata == cur.data, cur.req, prdata, cur.data);
        check(pslverr == cur.err, {cur.req, " pslverr"}, 32'(pslverr), 32'(cur.err));
        check(pready == 1'b1, "R8 pready", 32'(pready), 32'd1);
      end
    end
  end

  task automatic apbRead(logic [11:0] a, logic [31:0] exp, bit err, string req);
    expQ.push_back('{exp, err, req});
    @(posedge clk); #2;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #2;
    penable = 1'b1;
    @(posedge clk); #2;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apbWrite(logic [11:0] a, logic [31:0] d, bit err,
                          bit expRst, bit expShut, string req);
    @(posedge clk); #2;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #2;
    penable = 1'b1;
    @(negedge clk);
    check(pslverr == err, {req, " pslverr"}, 32'(pslverr), 32'(err));
    @(posedge clk); #2;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check(resetReq == expRst, {req, " resetReq"}, 32'(resetReq), 32'(expRst));
    check(shutdownReq == expShut, {req, " shutdownReq"}, 32'(shutdownReq), 32'(expShut));
    @(negedge clk);
    check(!resetReq && !shutdownReq, {req, " pulse width"},
          {30'd0, resetReq, shutdownReq}, '0);
  endtask

  // R9: a setup phase held without penable must do nothing
  task automatic setupOnly(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #2;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(!resetReq && !shutdownReq, "R9 setup-only request",
            {30'd0, resetReq, shutdownReq}, '0);
    end
    @(posedge clk); #2;
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check(!resetReq && !shutdownReq, "R9 setup-only request late",
          {30'd0, resetReq, shutdownReq}, '0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(prdata == '0, "R8 idle prdata after reset", prdata, '0);
    check(!resetReq && !shutdownReq, "R4 R5 no request after reset",
          {30'd0, resetReq, shutdownReq}, '0);

    // reset contents
    apbRead(12'h100, 32'h35F2_0121, 1'b0, "R1 R3 word 0x40");
    apbRead(12'h104, 32'h0000_0002, 1'b0, "R1 word 0x41");
    apbRead(12'h108, 32'h35F3_0121, 1'b0, "R1 R3 word 0x42");
    apbRead(12'h10C, 32'h35F4_0121, 1'b0, "R1 R3 word 0x43");
    apbRead(12'h000, 32'h0, 1'b0, "R1 word 0");
    apbRead(12'h7FC, 32'h0, 1'b0, "R1 last word");
    apbRead(12'h110, 32'h0, 1'b0, "R1 word 0x44");

    // storage
    apbWrite(12'h000, 32'hA5A5_A5A5, 1'b0, 1'b0, 1'b0, "R2 write word 0");
    apbRead(12'h000, 32'hA5A5_A5A5, 1'b0, "R2 readback word 0");
    apbWrite(12'h7FC, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R2 write last word");
    apbRead(12'h7FC, 32'h1234_5678, 1'b0, "R2 readback last word");

    // forcing
    apbWrite(12'h104, 32'h0000_00FF, 1'b0, 1'b0, 1'b0, "R3 write 0x104");
    apbRead(12'h104, 32'h0000_00FF, 1'b0, "R3 0x104 not forced");
    apbWrite(12'h100, 32'h0, 1'b0, 1'b0, 1'b0, "R3 write 0x100");
    apbRead(12'h100, 32'h3000_0000, 1'b0, "R3 0x100 forced over zero");
    apbWrite(12'h10C, 32'hC000_000F, 1'b0, 1'b0, 1'b0, "R3 write 0x10C");
    apbRead(12'h10C, 32'hF000_000F, 1'b0, "R3 0x10C forced");
    apbWrite(12'h108, 32'h3000_0001, 1'b0, 1'b0, 1'b0, "R3 write 0x108");
    apbRead(12'h108, 32'h3000_0001, 1'b0, "R3 0x108 already set");

    // commands
    apbWrite(12'hF00, 32'd1, 1'b1, 1'b1, 1'b0, "R4 cmd 1");
    apbWrite(12'hF00, 32'd2, 1'b1, 1'b1, 1'b0, "R4 cmd 2");
    apbWrite(12'hF00, 32'd3, 1'b1, 1'b0, 1'b1, "R5 cmd 3");
    apbWrite(12'hF00, 32'd0, 1'b1, 1'b0, 1'b0, "R6 cmd 0");
    apbWrite(12'hF00, 32'd4, 1'b1, 1'b0, 1'b0, "R6 cmd 4");
    apbWrite(12'hF00, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R6 cmd all ones");
    apbWrite(12'hF04, 32'd1, 1'b1, 1'b0, 1'b0, "R6 cmd 1 at 0xF04");
    apbWrite(12'h110, 32'd3, 1'b0, 1'b0, 1'b0, "R6 value 3 at 0x110");
    apbRead(12'h110, 32'd3, 1'b0, "R6 0x110 stored");

    // out of range
    apbWrite(12'h800, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, "R7 write 0x800");
    apbRead(12'h000, 32'hA5A5_A5A5, 1'b0, "R7 no alias onto word 0");
    apbRead(12'h800, 32'h0, 1'b1, "R7 read 0x800");
    apbRead(12'hF00, 32'h0, 1'b1, "R7 read command offset");
    apbRead(12'hFFC, 32'h0, 1'b1, "R7 read top of window");

    // setup phases alone
    setupOnly(12'h000, 32'h1111_1111);
    setupOnly(12'hF00, 32'd1);
    apbRead(12'h000, 32'hA5A5_A5A5, 1'b0, "R9 word 0 untouched");

    @(negedge clk);
    check(prdata == '0, "R8 idle prdata", prdata, '0);
    check(pready == 1'b1, "R8 idle pready", 32'(pready), 32'd1);
    check(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'd0);
    summary();
  end
endmodule